// File: doc/BRIEF.md
# Flash In-Application Programming Controller

This block lets an 8-bit processor core erase and program its own on-chip flash through four byte-wide registers. Software loads an address high byte, an address low byte and a data byte, then writes a command byte. The low seven bits of the command pick the operation. The top bit picks how completion is reported: through an interrupt or by polling a status flag.

The controller checks the command first. A valid command starts a busy timer whose length is a per-operation parameter. When the timer runs out, the operation takes effect on a small behavioural flash array. Erase sets bytes to FFh. Programming is refused on a byte that is not erased. Completion either feeds the interrupt-1 request in place of the external pin, or stays a status flag that software reads.

Top module: `flash_iap_ctrl`

## Requirements
- R1: Register offsets are 0 address high, 1 address low, 2 data and 3 command. Offsets 0 to 2 read back their contents. Reading offset 3 returns status: bit 0 busy, bit 1 done, bit 2 error, other bits 0. After reset every register reads 00h.
- R2: Command bits 6:0 select the operation: 01h chip erase, 0Dh block erase, 0Bh sector erase, 0Eh byte program, 06h burst program, 0Ch byte verify. Any other code is ignored: the block does not go busy and no status bit changes.
- R3: Chip erase and block erase are accepted only if the data register holds 55h when the command is written. Otherwise they are ignored, as in R2.
- R4: The array byte index is {address high bit 7, address low bits 6:0}. For block erase, address high bit 7 = 0 selects block 0 (indices 00h to 7Fh) and address high bits 7:4 = Fh selects block 1 (indices 80h to FFh). Any other address high value makes block erase ignored.
- R5: Busy is set from the edge that accepts a command and lasts exactly the operation's parameter count in cycles. Default test counts are chip 40, block 30, sector 20, byte 5, burst 4 and verify 2. Register writes made while busy are ignored.
- R6: The done flag is set when an operation completes. It is cleared when the next command is accepted.
- R7: Byte program and burst program write the data register into the addressed byte if that byte reads FFh. Otherwise the byte is unchanged and the error flag is set.
- R8: Byte verify loads the addressed byte into the data register on completion.
- R9: Chip erase sets every byte to FFh. Block erase sets its half of the array to FFh. Sector erase sets the 32-byte group that shares index bits 7:5 to FFh. No other bytes change.
- R10: When the last accepted command had bit 7 set, the interrupt-1 source is the done flag and the external pin has no effect. When bit 7 was clear, the external pin is the source.
- R11: The interrupt-1 request is asserted only when both the interrupt-1 enable and the global enable are high. With edge select high, it is a one-cycle pulse on a rising source. With edge select low, it follows the source level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ext_int1 | input | 1 | External interrupt-1 pin level |
| int1_en | input | 1 | Interrupt-1 enable |
| glob_en | input | 1 | Global interrupt enable |
| it1_edge | input | 1 | 1 = edge detection, 0 = level |
| int1_req | output | 1 | Interrupt-1 request to the core |

## Verification
A wrong timer load or a wrong expiry shows up in the busy bit. The number of cycles it stays high moves away from the operation's count, and this is visible in the first cycle after the expected end. A wrong decode or a wrong array update leaves no trace until a later byte verify returns a value other than FFh or the programmed byte, so each array effect is confirmed by reading back through a verify. A wrong interrupt-mode or source-mux state shows on the request pin in the same cycle as the pin change or the completion edge.

// File: rtl/flash_iap_pkg.sv
// Shared opcodes and sizes for the flash programming controller.
package flash_iap_pkg;
    typedef enum logic [6:0] {
        OP_CHIP   = 7'h01,
        OP_BLOCK  = 7'h0D,
        OP_SECTOR = 7'h0B,
        OP_BYTE   = 7'h0E,
        OP_BURST  = 7'h06,
        OP_VERIFY = 7'h0C
    } iap_op_e;

    localparam logic [7:0] ERASE_KEY = 8'h55;
    localparam logic [7:0] ERASED    = 8'hFF;
endpackage

// File: rtl/iap_cmd_decode.sv
// Command decoder: checks the opcode, the erase key and the block address,
// and gives the busy duration. Purely combinational; assumes nonzero counts.
module iap_cmd_decode
    import flash_iap_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int T_CHIP   = 40,
    parameter int T_BLOCK  = 30,
    parameter int T_SECTOR = 20,
    parameter int T_BYTE   = 5,
    parameter int T_BURST  = 4,
    parameter int T_VERIFY = 2
) (
    input  logic [6:0]       opcode,
    input  logic [7:0]       data_reg,
    input  logic [7:0]       addr_hi,
    output logic             cmd_ok,
    output logic [CNT_W-1:0] duration
);
    logic key_ok;
    logic blk_ok;

    assign key_ok = (data_reg == ERASE_KEY);
    assign blk_ok = (addr_hi[7] == 1'b0) || (addr_hi[7:4] == 4'hF);

    // Validity and timer length per operation
    always_comb begin
        cmd_ok   = 1'b0;
        duration = '0;
        case (opcode)
            OP_CHIP:   begin cmd_ok = key_ok;          duration = CNT_W'(T_CHIP);   end
            OP_BLOCK:  begin cmd_ok = key_ok && blk_ok; duration = CNT_W'(T_BLOCK);  end
            OP_SECTOR: begin cmd_ok = 1'b1;            duration = CNT_W'(T_SECTOR); end
            OP_BYTE:   begin cmd_ok = 1'b1;            duration = CNT_W'(T_BYTE);   end
            OP_BURST:  begin cmd_ok = 1'b1;            duration = CNT_W'(T_BURST);  end
            OP_VERIFY: begin cmd_ok = 1'b1;            duration = CNT_W'(T_VERIFY); end
            default:   begin cmd_ok = 1'b0;            duration = '0;               end
        endcase
    end
endmodule

// File: rtl/iap_busy_timer.sv
// Busy timer: loads a count on start and raises a one-cycle expiry when it
// has run that many cycles. Assumes start is only given while idle.
module iap_busy_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] length,
    output logic             busy,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    assign expire = busy && (cnt_q == '0);

    // Count down from length-1 while busy; drop busy on expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= length - 1'b1;
        end else if (expire) begin
            busy  <= 1'b0;
        end else if (busy) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/iap_flash_array.sv
// Behavioural flash array. Resets to the erased state and applies an
// operation on the apply strobe. Programming only happens on erased bytes;
// the caller flags errors from rd_data.
module iap_flash_array
    import flash_iap_pkg::*;
#(
    parameter int MEM_AW  = 8,
    parameter int SECT_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apply,
    input  iap_op_e           op,
    input  logic [MEM_AW-1:0] idx,
    input  logic [7:0]        wdata,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [7:0] mem [DEPTH];

    assign rd_data = mem[idx];

    // Per-entry erase and program update
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                mem[i] <= ERASED;
            end else if (apply) begin
                case (op)
                    OP_CHIP: mem[i] <= ERASED;
                    OP_BLOCK:
                        if (i[MEM_AW-1] == idx[MEM_AW-1]) mem[i] <= ERASED;
                    OP_SECTOR:
                        if ((i >> SECT_AW) == int'(idx >> SECT_AW)) mem[i] <= ERASED;
                    OP_BYTE, OP_BURST:
                        if (i == int'(idx) && mem[i] == ERASED) mem[i] <= wdata;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/flash_iap_ctrl.sv
// Flash programming controller top: register file, command acceptance,
// completion flags and the interrupt-1 source selection with gating.
// Assumes a single-cycle register write strobe from the core.
module flash_iap_ctrl
    import flash_iap_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int MEM_AW   = 8,
    parameter int SECT_AW  = 5,
    parameter int T_CHIP   = 40,
    parameter int T_BLOCK  = 30,
    parameter int T_SECTOR = 20,
    parameter int T_BYTE   = 5,
    parameter int T_BURST  = 4,
    parameter int T_VERIFY = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       ext_int1,
    input  logic       int1_en,
    input  logic       glob_en,
    input  logic       it1_edge,
    output logic       int1_req
);
    logic [7:0]        addr_hi_q, addr_lo_q, data_q;
    iap_op_e           op_q;
    logic              irq_mode_q, done_q, err_q, src_q;
    logic              busy, expire, cmd_ok, accept, int1_src;
    logic [CNT_W-1:0]  duration;
    logic [7:0]        arr_rd;
    logic [MEM_AW-1:0] idx;

    assign idx    = {addr_hi_q[7], addr_lo_q[MEM_AW-2:0]};
    assign accept = reg_we && !busy && (reg_addr == 2'd3) && cmd_ok;

    iap_cmd_decode #(
        .CNT_W(CNT_W), .T_CHIP(T_CHIP), .T_BLOCK(T_BLOCK), .T_SECTOR(T_SECTOR),
        .T_BYTE(T_BYTE), .T_BURST(T_BURST), .T_VERIFY(T_VERIFY)
    ) i_dec (
        .opcode(reg_wdata[6:0]), .data_reg(data_q), .addr_hi(addr_hi_q),
        .cmd_ok(cmd_ok), .duration(duration)
    );

    iap_busy_timer #(.CNT_W(CNT_W)) i_tmr (
        .clk(clk), .rst_n(rst_n), .start(accept), .length(duration),
        .busy(busy), .expire(expire)
    );

    iap_flash_array #(.MEM_AW(MEM_AW), .SECT_AW(SECT_AW)) i_arr (
        .clk(clk), .rst_n(rst_n), .apply(expire), .op(op_q), .idx(idx),
        .wdata(data_q), .rd_data(arr_rd)
    );

    // Register writes while idle, command latch, completion flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_hi_q  <= '0;
            addr_lo_q  <= '0;
            data_q     <= '0;
            op_q       <= OP_VERIFY;
            irq_mode_q <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else if (expire) begin
            done_q <= 1'b1;
            if (op_q == OP_VERIFY) data_q <= arr_rd;
            if ((op_q == OP_BYTE || op_q == OP_BURST) && arr_rd != ERASED) err_q <= 1'b1;
        end else if (reg_we && !busy) begin
            case (reg_addr)
                2'd0: addr_hi_q <= reg_wdata;
                2'd1: addr_lo_q <= reg_wdata;
                2'd2: data_q    <= reg_wdata;
                default:
                    if (cmd_ok) begin
                        op_q       <= iap_op_e'(reg_wdata[6:0]);
                        irq_mode_q <= reg_wdata[7];
                        done_q     <= 1'b0;
                        err_q      <= 1'b0;
                    end
            endcase
        end
    end

    // Previous interrupt source level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= 1'b0;
        else        src_q <= int1_src;
    end

    assign int1_src = irq_mode_q ? done_q : ext_int1;
    assign int1_req = int1_en && glob_en &&
                      (it1_edge ? (int1_src && !src_q) : int1_src);

    // Register read mux
    always_comb begin
        case (reg_addr)
            2'd0:    reg_rdata = addr_hi_q;
            2'd1:    reg_rdata = addr_lo_q;
            2'd2:    reg_rdata = data_q;
            default: reg_rdata = {5'b0, err_q, done_q, busy};
        endcase
    end
endmodule

// File: rtl/flash_iap_ctrl_checker.sv
// Temporal checks for the flash programming controller, bound to the top.
module flash_iap_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [1:0] reg_addr,
    input logic       busy,
    input logic       cmd_ok,
    input logic       done_q,
    input logic [7:0] addr_hi_q,
    input logic [7:0] data_q,
    input logic       int1_req,
    input logic       int1_en,
    input logic       glob_en,
    input logic       it1_edge
);
    // R5
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && reg_we && reg_addr == 2'd3 && cmd_ok) |=> busy);
    // R2
    reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && reg_we && reg_addr == 2'd3 && !cmd_ok) |=> !busy);
    // R5
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_addr == 2'd0) |=> $stable(addr_hi_q));
    // R5
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_addr == 2'd2 && $past(busy) && busy) |=> ($stable(data_q) || !busy));
    // R6
    done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_q);
    // R11
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int1_req |-> (int1_en && glob_en));
    // R11
    pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int1_req && it1_edge) |=> !(int1_req && it1_edge));
endmodule

bind flash_iap_ctrl flash_iap_ctrl_checker i_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .busy(busy), .cmd_ok(cmd_ok), .done_q(done_q), .addr_hi_q(addr_hi_q),
    .data_q(data_q), .int1_req(int1_req), .int1_en(int1_en),
    .glob_en(glob_en), .it1_edge(it1_edge)
);

// File: tb/test_flash_iap_ctrl.sv
// Directed bench for the flash programming controller.
module test_flash_iap_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       ext_int1 = 1'b0;
    logic       int1_en = 1'b0;
    logic       glob_en = 1'b0;
    logic       it1_edge = 1'b0;
    logic       int1_req;

    int checks = 0;
    int errors = 0;
    int irq_hits;

    flash_iap_ctrl i_flash_iap_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_int1(ext_int1),
        .int1_en(int1_en), .glob_en(glob_en), .it1_edge(it1_edge),
        .int1_req(int1_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Issue a command; return busy length in cycles; count request samples
    task automatic run_cmd(input logic [7:0] cmd, output int len);
        logic [7:0] s;
        len = 0;
        irq_hits = 0;
        wr(2'd3, cmd);
        rd(2'd3, s);
        while (s[0] && len < 1000) begin
            len++;
            @(negedge clk);
            if (int1_req) irq_hits++;
            rd(2'd3, s);
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (int1_req) irq_hits++;
        end
    endtask

    task automatic setup(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] d);
        wr(2'd0, hi); wr(2'd1, lo); wr(2'd2, d);
    endtask

    task automatic verify_byte(input logic [7:0] hi, input logic [7:0] lo,
                               input int exp, input string req);
        int len;
        logic [7:0] v;
        setup(hi, lo, 8'h00);
        run_cmd(8'h0C, len);
        rd(2'd2, v);
        check(req, v, exp);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check("R1 reset value", v, 0);
        end
        verify_byte(8'h00, 8'h33, 8'hFF, "R8 verify of erased byte");
    endtask

    task automatic t_program;
        int len;
        logic [7:0] s;
        setup(8'h00, 8'h05, 8'hA5);
        run_cmd(8'h0E, len);
        check("R5 byte program length", len, 5);
        rd(2'd3, s);
        check("R6 done, no error", s, 8'h02);
        verify_byte(8'h00, 8'h05, 8'hA5, "R7 programmed byte");
        setup(8'h00, 8'h05, 8'h5A);
        run_cmd(8'h0E, len);
        rd(2'd3, s);
        check("R7 error on non-erased program", s, 8'h06);
        verify_byte(8'h00, 8'h05, 8'hA5, "R7 byte unchanged");
        setup(8'h00, 8'h06, 8'hC3);
        run_cmd(8'h06, len);
        check("R5 burst length", len, 4);
        verify_byte(8'h00, 8'h06, 8'hC3, "R7 burst program");
    endtask

    task automatic t_sector;
        int len;
        setup(8'h00, 8'h45, 8'h11);
        run_cmd(8'h0E, len);
        setup(8'h00, 8'h1F, 8'h00);
        run_cmd(8'h0B, len);
        check("R5 sector length", len, 20);
        verify_byte(8'h00, 8'h05, 8'hFF, "R9 sector erased");
        verify_byte(8'h00, 8'h45, 8'h11, "R9 other sector kept");
    endtask

    task automatic t_block;
        int len;
        setup(8'h80, 8'h10, 8'h3C); run_cmd(8'h0E, len);
        setup(8'h00, 8'h10, 8'h3C); run_cmd(8'h0E, len);
        setup(8'h80, 8'h00, 8'h55);
        run_cmd(8'h0D, len);
        check("R4 block erase bad high byte ignored", len, 0);
        verify_byte(8'h80, 8'h10, 8'h3C, "R4 nothing erased");
        setup(8'hF0, 8'h00, 8'h55);
        run_cmd(8'h0D, len);
        check("R5 block length", len, 30);
        verify_byte(8'h80, 8'h10, 8'hFF, "R9 block 1 erased");
        verify_byte(8'h00, 8'h10, 8'h3C, "R4 block 0 kept");
    endtask

    task automatic t_chip_key;
        int len;
        logic [7:0] s;
        setup(8'h00, 8'h00, 8'h54);
        run_cmd(8'h01, len);
        check("R3 chip erase without key ignored", len, 0);
        rd(2'd3, s);
        check("R3 status unchanged", s, 8'h02);
        setup(8'h00, 8'h00, 8'h00);
        run_cmd(8'h0D, len);
        check("R3 block erase without key ignored", len, 0);
        verify_byte(8'h00, 8'h10, 8'h3C, "R3 byte kept");
        setup(8'h12, 8'h34, 8'h55);
        run_cmd(8'h01, len);
        check("R5 chip length", len, 40);
        verify_byte(8'h00, 8'h10, 8'hFF, "R9 chip erased");
        verify_byte(8'h00, 8'h45, 8'hFF, "R9 chip erased other");
    endtask

    task automatic t_invalid_busy;
        int len;
        logic [7:0] s;
        run_cmd(8'h0F, len);
        check("R2 unknown code ignored", len, 0);
        run_cmd(8'h00, len);
        check("R2 zero code ignored", len, 0);
        setup(8'h21, 8'h00, 8'h55);
        wr(2'd3, 8'h01);
        rd(2'd3, s);
        check("R6 done cleared on accept", s, 8'h01);
        wr(2'd0, 8'h77);
        wr(2'd2, 8'h99);
        repeat (50) @(negedge clk);
        rd(2'd0, s);
        check("R5 address write while busy ignored", s, 8'h21);
        rd(2'd2, s);
        check("R5 data write while busy ignored", s, 8'h55);
    endtask

    task automatic t_interrupt;
        int len;
        int_en_all();
        it1_edge = 1'b1;
        setup(8'h00, 8'h00, 8'h00);
        run_cmd(8'h8C, len);
        check("R11 single edge pulse", irq_hits, 1);
        it1_edge = 1'b0;
        #1 check("R11 level follows done", int1_req, 1);
        glob_en = 1'b0;
        #1 check("R11 global enable gates", int1_req, 0);
        glob_en = 1'b1; int1_en = 1'b0;
        #1 check("R11 int1 enable gates", int1_req, 0);
        int1_en = 1'b1;
        setup(8'h00, 8'h00, 8'h00);
        wr(2'd3, 8'h8B);
        ext_int1 = 1'b1;
        #1 check("R10 pin disconnected in interrupt mode", int1_req, 0);
        repeat (25) @(negedge clk);
        ext_int1 = 1'b0;
        wr(2'd3, 8'h0B);
        ext_int1 = 1'b1;
        #1 check("R10 pin is source in poll mode", int1_req, 1);
        ext_int1 = 1'b0;
        #1 check("R10 pin low in poll mode", int1_req, 0);
        repeat (25) @(negedge clk);
        #1 check("R10 done not routed in poll mode", int1_req, 0);
        int1_en = 1'b0; glob_en = 1'b0;
    endtask

    task automatic int_en_all;
        int1_en = 1'b1; glob_en = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_sector();
        t_block();
        t_chip_key();
        t_invalid_busy();
        t_interrupt();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule